// File: doc/BRIEF.md
# Summary Interrupt Cause Aggregator

This block merges three group-level interrupt requests into one host interrupt line. The three groups carry receive, transmit and miscellaneous events. Each group presents a single level that is high while that group has anything pending. The block keeps a sticky summary cause word with one bit per group. A small register port lets software read that word, and reading it clears it. The same port reads and writes a software mask that gates the host line.

A typical handler sets every mask bit on entry, so the line drops while it works. It then reads the cause word to learn which groups need service. On exit it writes a mask value with the three summary bit positions cleared, unless deferred work means the line should stay quiet. A group request that arrives in the same cycle as a clearing read is latched again on the next edge, so no event is lost.

Top module: `summary_irq_agg`

## Requirements
- R1: After reset the cause word is zero, all mask bits are one, `host_irq` is low and `reg_rdata` is zero.
- R2: A high level on `grp_req[i]` at a clock edge sets cause bit i at that edge. Bit 0 is receive, bit 1 is transmit and bit 2 is miscellaneous. Cause bits 3 and up always read as zero.
- R3: A read (`reg_valid`=1, `reg_write`=0) of word address 0 loads the current cause word into `reg_rdata` at that edge and clears the cause word at the same edge. `reg_rdata` holds its value until the next read.
- R4: If a group request is high in the same cycle as a clearing read, that read returns the cause word from before the edge, and the bit is set again after that edge, so a later read returns it.
- R5: A write to word address 1 stores `reg_wdata[2:0]` as the mask for the three cause bits. A read of address 1 returns the stored bits in [2:0] and ones in every higher bit.
- R6: `host_irq` is high exactly when some cause bit is set while its mask bit is clear, and it follows the registered state with no further delay.
- R7: A write to address 0, or any access to an address other than 0 and 1, changes neither the cause word nor the mask. A read of an unmapped address returns zero.
- R8: Writing 0xFFFFFFF8 unmasks all three sources. Writing all ones takes `host_irq` low in the cycle after the write, and the cause bits stay latched.
- R9: Reading the mask register leaves the cause word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_req | input | 3 | Pending levels of the groups: [0] receive, [1] transmit, [2] miscellaneous |
| reg_valid | input | 1 | Register access request for this cycle |
| reg_write | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | ADDR_W | Word address: 0 for cause, 1 for mask |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered, held between reads |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
The assertions assume that `grp_req` and the register port are driven synchronously. They also assume that a register access lasts exactly one cycle per valid request, so every valid read of address 0 counts as one clearing read. The stimulus changes inputs only on the falling edge and never holds an access across cycles unless it means to repeat it. Random group levels overlap with clearing reads, mask writes and accesses to unmapped addresses. Directed cases pin down the same-cycle set-and-clear race and the mask-at-entry, unmask-at-exit sequence.

// File: rtl/sia_pkg.sv
package sia_pkg;
    localparam int NUM_SRC  = 3;
    localparam int SRC_RX   = 0;
    localparam int SRC_TX   = 1;
    localparam int SRC_MISC = 2;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CAUSE = 2'd1,
        SEL_MASK  = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/sia_cause_latch.sv
module sia_cause_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] grp_req,
    input  logic         clr,
    output logic [N-1:0] cause_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cause_q[i] <= 1'b0;
            end else begin
                // a request in the clearing cycle wins, so it is never lost
                cause_q[i] <= grp_req[i] | (cause_q[i] & ~clr);
            end
        end

        p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            grp_req[i] |=> cause_q[i]);
        p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !grp_req[i]) |=> !cause_q[i]);
    end
endmodule

// File: rtl/sia_reg_port.sv
module sia_reg_port
    import sia_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int N          = 3,
    parameter int CAUSE_ADDR = 0,
    parameter int MASK_ADDR  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [N-1:0]      cause_q,
    output logic [N-1:0]      mask_q,
    output logic              rd_clr,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int PAD_W = DATA_W - N;

    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_mux;
    logic              rd_en;
    logic              mask_we;

    always_comb begin
        if (reg_addr == ADDR_W'(CAUSE_ADDR))     sel = SEL_CAUSE;
        else if (reg_addr == ADDR_W'(MASK_ADDR)) sel = SEL_MASK;
        else                                     sel = SEL_NONE;
    end

    assign rd_en   = reg_valid && !reg_write;
    assign rd_clr  = rd_en && (sel == SEL_CAUSE);
    assign mask_we = reg_valid && reg_write && (sel == SEL_MASK);

    always_comb begin
        unique case (sel)
            SEL_CAUSE: rd_mux = {{PAD_W{1'b0}}, cause_q};
            SEL_MASK:  rd_mux = {{PAD_W{1'b1}}, mask_q};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '1;
            reg_rdata <= '0;
        end else begin
            if (mask_we) mask_q <= reg_wdata[N-1:0];
            if (rd_en)   reg_rdata <= rd_mux;
        end
    end

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_valid && reg_write && reg_addr == ADDR_W'(MASK_ADDR)) |=> $stable(mask_q));
    p_unmapped_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr != ADDR_W'(CAUSE_ADDR) && reg_addr != ADDR_W'(MASK_ADDR))
        |=> (reg_rdata == '0));
    p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(reg_rdata));
endmodule

// File: rtl/sia_irq_gate.sv
module sia_irq_gate #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cause_q,
    input  logic [N-1:0] mask_q,
    output logic         host_irq
);
    logic [N-1:0] live;

    assign live     = cause_q & ~mask_q;
    assign host_irq = |live;

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !host_irq);
    p_no_cause_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q == '0) |-> !host_irq);
endmodule

// File: rtl/summary_irq_agg.sv
module summary_irq_agg
    import sia_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int CAUSE_ADDR = 0,
    parameter int MASK_ADDR  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] grp_req,
    input  logic               reg_valid,
    input  logic               reg_write,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               host_irq
);
    logic [NUM_SRC-1:0] cause_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               rd_clr;

    sia_cause_latch #(.N(NUM_SRC)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .grp_req (grp_req),
        .clr     (rd_clr),
        .cause_q (cause_q)
    );

    sia_reg_port #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .N          (NUM_SRC),
        .CAUSE_ADDR (CAUSE_ADDR),
        .MASK_ADDR  (MASK_ADDR)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cause_q   (cause_q),
        .mask_q    (mask_q),
        .rd_clr    (rd_clr),
        .reg_rdata (reg_rdata)
    );

    sia_irq_gate #(.N(NUM_SRC)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .cause_q  (cause_q),
        .mask_q   (mask_q),
        .host_irq (host_irq)
    );

    p_mask_rd_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && reg_addr == ADDR_W'(MASK_ADDR) && grp_req == '0)
        |=> $stable(cause_q));
endmodule

// File: tb/summary_irq_agg_tb_top.sv
`timescale 1ns/1ps
module summary_irq_agg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  grp_req = '0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [2:0]  m_cause = '0;
    logic [2:0]  m_mask  = '1;
    logic [31:0] m_rdata = '0;

    always #10 clk = ~clk;

    summary_irq_agg dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_req   (grp_req),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .host_irq  (host_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_model(input logic [3:0] a);
        if (a == 4'd0)      return {29'd0, m_cause};
        else if (a == 4'd1) return {29'h1FFF_FFFF, m_mask};
        else                return 32'd0;
    endfunction

    // drive at the falling edge, model at the rising edge, check at the next falling edge
    task automatic cyc(input logic [2:0] req, input logic v, input logic w,
                       input logic [3:0] a, input logic [31:0] d);
        logic clr;
        grp_req = req; reg_valid = v; reg_write = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        clr = v && !w && (a == 4'd0);
        if (v && !w) m_rdata = rd_model(a);
        if (v && w && a == 4'd1) m_mask = d[2:0];
        m_cause = req | (m_cause & (clr ? 3'b000 : 3'b111));
        @(negedge clk);
        grp_req = '0; reg_valid = 1'b0; reg_write = 1'b0;
        chk("R6 host_irq", {31'd0, host_irq}, {31'd0, |(m_cause & ~m_mask)});
        chk("R3 reg_rdata", reg_rdata, m_rdata);
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        cyc(3'b000, 1'b1, 1'b0, a, 32'd0);
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq after reset", {31'd0, host_irq}, 32'd0);
        chk("R1 rdata after reset", reg_rdata, 32'd0);
        rd(4'd1, 32'hFFFF_FFFF, "R1 mask all ones");
        rd(4'd0, 32'd0, "R1 cause zero");

        // R2 set by a one-cycle pulse; still masked
        cyc(3'b010, 1'b0, 1'b0, 4'd0, 32'd0);
        chk("R8 masked line low", {31'd0, host_irq}, 32'd0);
        rd(4'd0, 32'h0000_0002, "R2 transmit bit 1");
        rd(4'd0, 32'h0000_0000, "R3 cleared by read");

        // R8 unmask, then mask at entry
        cyc(3'b000, 1'b1, 1'b1, 4'd1, 32'hFFFF_FFF8);
        rd(4'd1, 32'hFFFF_FFF8, "R5 mask readback");
        cyc(3'b001, 1'b0, 1'b0, 4'd0, 32'd0);
        chk("R8 unmasked line high", {31'd0, host_irq}, 32'd1);
        cyc(3'b000, 1'b1, 1'b1, 4'd1, 32'hFFFF_FFFF);
        chk("R8 line low after mask", {31'd0, host_irq}, 32'd0);
        rd(4'd0, 32'h0000_0001, "R8 cause kept while masked");

        // R4 request during clearing read
        cyc(3'b100, 1'b0, 1'b0, 4'd0, 32'd0);
        cyc(3'b100, 1'b1, 1'b0, 4'd0, 32'd0);
        chk("R4 read returns old word", reg_rdata, 32'h0000_0004);
        rd(4'd0, 32'h0000_0004, "R4 relatched after clear");
        rd(4'd0, 32'h0000_0000, "R4 then clear");

        // R7 ignored accesses
        cyc(3'b001, 1'b0, 1'b0, 4'd0, 32'd0);
        cyc(3'b000, 1'b1, 1'b1, 4'd0, 32'h0000_0000);
        cyc(3'b000, 1'b1, 1'b1, 4'd5, 32'h0000_0000);
        rd(4'd1, 32'hFFFF_FFFF, "R7 mask untouched by unmapped write");
        rd(4'd7, 32'h0000_0000, "R7 unmapped read zero");
        // R9 mask read keeps cause
        rd(4'd1, 32'hFFFF_FFFF, "R9 mask read");
        rd(4'd0, 32'h0000_0001, "R9 cause kept R7 cause write ignored");

        // partial mask per source
        cyc(3'b000, 1'b1, 1'b1, 4'd1, 32'hFFFF_FFFB);
        cyc(3'b011, 1'b0, 1'b0, 4'd0, 32'd0);
        chk("R6 only unmasked source counts", {31'd0, host_irq}, 32'd0);
        cyc(3'b100, 1'b0, 1'b0, 4'd0, 32'd0);
        chk("R6 misc unmasked", {31'd0, host_irq}, 32'd1);
        rd(4'd0, 32'h0000_0007, "R2 all three bits");

        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic [2:0]  r_req;
            logic [31:0] r_d;
            r_req = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
            case ($urandom % 3)
                0:       r_d = 32'hFFFF_FFF8;
                1:       r_d = 32'hFFFF_FFFF;
                default: r_d = $urandom;
            endcase
            cyc(r_req, 1'($urandom % 2), 1'($urandom % 3 == 0), 4'($urandom % 4), r_d);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule